// File: doc/BRIEF.md
# Dual-Mode Host Bus Bridge

This block connects an asynchronous, non-multiplexed parallel host bus to a simple internal register bus. That register bus serves eight identical framer channels and one bank of global registers. A static mode input picks one of two host bus styles:
- Separate-strobe style: one active-low read strobe and one active-low write strobe.
- Data-strobe style: a single active-low data strobe plus a read/write direction line.

The chip select and both strobe lines pass through two-flop synchronizers into the system clock. Each detected strobe edge produces exactly one single-cycle internal read or write enable.

The upper nibble of the 12-bit host address chooses the target:
- one framer channel;
- all eight channels at once, for a write;
- the global bank;
- or nothing.

The lower byte is passed through as the register offset. Read data comes back from the selected target. It is held on a data-out/output-enable pair, which the host-side pad uses to drive the 16-bit bus during a selected read.

Eight per-channel interrupt lines are merged into one open-drain request. The request is modelled as an enable that pulls the line low.

Top module: `hostbus_bridge`

## Requirements
- R1: While reset is asserted and right after it, every internal enable, `data_oe`, `data_out` and `irq_n_oe` is zero.
- R2: In data-strobe mode (`mode_sep`=0), a falling strobe on `rd_ds_n` with `cs_n` low and `wr_rw`=0 is a write. It gives exactly one cycle of write enable, with `reg_addr`=addr[7:0] and `reg_wdata`=`data_in`. The enable appears three clock edges after the strobe change.
- R3: In separate-strobe mode (`mode_sep`=1), the address is captured when `wr_rw` (the write strobe) falls. The write itself, using that captured address and the `data_in` present at that time, is issued one cycle long three edges after the write strobe rises. An address change between the two strobe edges has no effect.
- R4: A read is started by the `rd_ds_n` strobe falling. In data-strobe mode this needs `wr_rw`=1; in separate-strobe mode `rd_ds_n` is the read strobe. The read gives a one-cycle read enable to the target. One cycle later `data_out` holds the target's read data. `data_oe` is high while the read strobe is active and `cs_n` is low.
- R5: When addr[11]=1 and addr[10:8]=000, a write asserts all eight framer write enables in the same cycle.
- R6: A read at the all-channel address asserts no read enable and returns 0.
- R7: When addr[11]=1, addr[10]=0, addr[9]=0 and addr[8]=1, the access goes to the global bank (`gl_wr_en`/`gl_rd_en`) instead of a framer.
- R8: When addr[11]=1 and either addr[9]=1 or addr[10:8]=101, the access is unmapped. A write asserts no enable, and a read asserts none and returns 0.
- R9: While `cs_n` is high, strobe edges produce no enable and `data_oe` stays 0.
- R10: `irq_n_oe` is 1, pulling the request low, one cycle after any `fr_irq` bit is high, whatever the state of `cs_n`.
- R11: When addr[11]=0, addr[10:8] selects the single framer channel whose enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sep | input | 1 | 1: separate read/write strobes; 0: data strobe plus direction |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe (mode 1) or data strobe (mode 0), active low |
| wr_rw | input | 1 | Write strobe, active low (mode 1), or direction line, 1=read (mode 0) |
| addr | input | 12 | Host address |
| data_in | input | 16 | Host write data from the pad |
| data_out | output | 16 | Read data toward the pad |
| data_oe | output | 1 | Pad drive enable for the data bus |
| reg_addr | output | 8 | Register offset on the internal bus |
| reg_wdata | output | 16 | Internal write data |
| fr_wr_en | output | 8 | Per-channel write enables |
| fr_rd_en | output | 8 | Per-channel read enables |
| fr_rdata | input | 128 | Per-channel read data, channel n at bits 16n+15:16n |
| gl_wr_en | output | 1 | Global bank write enable |
| gl_rd_en | output | 1 | Global bank read enable |
| gl_rdata | input | 16 | Global bank read data |
| fr_irq | input | 8 | Per-channel interrupt requests, active high |
| irq_n_oe | output | 1 | Open-drain pull-down enable for the merged interrupt |

## Verification
Faults in the synchronizer or edge-detect state show up as the enable pulse arriving a cycle early or late, lasting two cycles, or never arriving. The bench pins these down by sampling the enables exactly on the third edge after a strobe change and again one cycle later.

A stale or wrongly updated held address in separate-strobe mode shows up as a write enable on the wrong channel within three cycles of the write strobe rising. The bench moves the address between the two strobe edges to expose this.

A wrong read target latch shows up one cycle after the read enable, as wrong or nonzero `data_out`.

// File: rtl/hostbus_pkg.sv
`timescale 1ns/1ps
package hostbus_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int N_FR   = 8;
    localparam int SEL_W  = $clog2(N_FR);
    localparam int REG_W  = ADDR_W - 1 - SEL_W;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_FRAMER = 2'd1,
        TGT_BCAST  = 2'd2,
        TGT_GLOBAL = 2'd3
    } tgt_e;
endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL, s3: RST_VAL};
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.s3;
endmodule

// File: rtl/hb_decode.sv
`timescale 1ns/1ps
module hb_decode
    import hostbus_pkg::*;
(
    input  logic             top_bit,
    input  logic [SEL_W-1:0] sel,
    output tgt_e             tgt,
    output logic [SEL_W-1:0] ch
);
    always_comb begin
        ch = sel;
        if (!top_bit)
            tgt = TGT_FRAMER;
        else if (sel == '0)
            tgt = TGT_BCAST;
        else if (!sel[1] && sel[0] && !sel[SEL_W-1])
            tgt = TGT_GLOBAL;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/hb_rdmux.sv
`timescale 1ns/1ps
module hb_rdmux
    import hostbus_pkg::*;
(
    input  tgt_e                     tgt,
    input  logic [SEL_W-1:0]         ch,
    input  logic [N_FR*DATA_W-1:0]   fr_rdata,
    input  logic [DATA_W-1:0]        gl_rdata,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] lanes [N_FR];

    for (genvar g = 0; g < N_FR; g++) begin : g_lane
        assign lanes[g] = fr_rdata[g*DATA_W +: DATA_W];
    end

    always_comb begin
        unique case (tgt)
            TGT_FRAMER: rdata = lanes[ch];
            TGT_GLOBAL: rdata = gl_rdata;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/hostbus_bridge.sv
`timescale 1ns/1ps
module hostbus_bridge
    import hostbus_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_sep,
    input  logic                      cs_n,
    input  logic                      rd_ds_n,
    input  logic                      wr_rw,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         data_in,
    output logic [DATA_W-1:0]         data_out,
    output logic                      data_oe,
    output logic [REG_W-1:0]          reg_addr,
    output logic [DATA_W-1:0]         reg_wdata,
    output logic [N_FR-1:0]           fr_wr_en,
    output logic [N_FR-1:0]           fr_rd_en,
    input  logic [N_FR*DATA_W-1:0]    fr_rdata,
    output logic                      gl_wr_en,
    output logic                      gl_rd_en,
    input  logic [DATA_W-1:0]         gl_rdata,
    input  logic [N_FR-1:0]           fr_irq,
    output logic                      irq_n_oe
);
    localparam int IDX_CS = 2;
    localparam int IDX_RD = 1;
    localparam int IDX_WR = 0;

    typedef struct packed {
        logic [ADDR_W-1:0] addr_hold;
        logic [REG_W-1:0]  reg_addr;
        logic [DATA_W-1:0] wdata;
        logic [N_FR-1:0]   fr_wr;
        logic [N_FR-1:0]   fr_rd;
        logic              gl_wr;
        logic              gl_rd;
        logic              rd_pend;
        tgt_e              rd_tgt;
        logic [SEL_W-1:0]  rd_ch;
        logic [DATA_W-1:0] dout;
        logic              oe;
        logic              irq;
    } br_st_t;

    br_st_t st_d, st_q;

    logic [2:0] s_cur, s_prev;
    logic       cs_act, rd_fall, wr_fall, wr_rise;
    logic       rd_evt, wr_evt;
    logic [ADDR_W-1:0] acc_addr;
    tgt_e              dec_tgt;
    logic [SEL_W-1:0]  dec_ch;
    logic [DATA_W-1:0] mux_data;

    hb_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, rd_ds_n, wr_rw}),
        .cur      (s_cur),
        .prev     (s_prev)
    );

    assign cs_act  = ~s_cur[IDX_CS];
    assign rd_fall = s_prev[IDX_RD] & ~s_cur[IDX_RD];
    assign wr_fall = s_prev[IDX_WR] & ~s_cur[IDX_WR];
    assign wr_rise = ~s_prev[IDX_WR] & s_cur[IDX_WR];

    // Event detection and choice of the address used by this access
    always_comb begin
        rd_evt   = 1'b0;
        wr_evt   = 1'b0;
        acc_addr = addr;
        if (mode_sep) begin
            rd_evt = cs_act & rd_fall;
            if (cs_act & wr_rise) begin
                wr_evt   = 1'b1;
                acc_addr = st_q.addr_hold;
            end
        end else if (cs_act & rd_fall) begin
            rd_evt = s_cur[IDX_WR];
            wr_evt = ~s_cur[IDX_WR];
        end
    end

    hb_decode u_decode (
        .top_bit (acc_addr[ADDR_W-1]),
        .sel     (acc_addr[ADDR_W-2 -: SEL_W]),
        .tgt     (dec_tgt),
        .ch      (dec_ch)
    );

    hb_rdmux u_rdmux (
        .tgt      (st_q.rd_tgt),
        .ch       (st_q.rd_ch),
        .fr_rdata (fr_rdata),
        .gl_rdata (gl_rdata),
        .rdata    (mux_data)
    );

    always_comb begin
        st_d         = st_q;
        st_d.fr_wr   = '0;
        st_d.fr_rd   = '0;
        st_d.gl_wr   = 1'b0;
        st_d.gl_rd   = 1'b0;
        st_d.rd_pend = 1'b0;

        if (mode_sep && cs_act && wr_fall)
            st_d.addr_hold = addr;

        if (wr_evt) begin
            st_d.reg_addr = acc_addr[REG_W-1:0];
            st_d.wdata    = data_in;
            unique case (dec_tgt)
                TGT_FRAMER: st_d.fr_wr[dec_ch] = 1'b1;
                TGT_BCAST:  st_d.fr_wr = '1;
                TGT_GLOBAL: st_d.gl_wr = 1'b1;
                default:    ;
            endcase
        end

        if (rd_evt) begin
            st_d.reg_addr = acc_addr[REG_W-1:0];
            st_d.rd_pend  = 1'b1;
            st_d.rd_tgt   = dec_tgt;
            st_d.rd_ch    = dec_ch;
            unique case (dec_tgt)
                TGT_FRAMER: st_d.fr_rd[dec_ch] = 1'b1;
                TGT_GLOBAL: st_d.gl_rd = 1'b1;
                default:    ;
            endcase
        end

        if (st_q.rd_pend)
            st_d.dout = mux_data;

        st_d.oe  = cs_act & (mode_sep ? ~s_cur[IDX_RD]
                                      : (~s_cur[IDX_RD] & s_cur[IDX_WR]));
        st_d.irq = |fr_irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rd_tgt <= TGT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out  = st_q.dout;
    assign data_oe   = st_q.oe;
    assign reg_addr  = st_q.reg_addr;
    assign reg_wdata = st_q.wdata;
    assign fr_wr_en  = st_q.fr_wr;
    assign fr_rd_en  = st_q.fr_rd;
    assign gl_wr_en  = st_q.gl_wr;
    assign gl_rd_en  = st_q.gl_rd;
    assign irq_n_oe  = st_q.irq;
endmodule

// File: rtl/hostbus_bridge_chk.sv
`timescale 1ns/1ps
module hostbus_bridge_chk
    import hostbus_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [N_FR-1:0] fr_wr_en,
    input logic [N_FR-1:0] fr_rd_en,
    input logic            gl_wr_en,
    input logic            gl_rd_en,
    input logic            data_oe,
    input logic [N_FR-1:0] fr_irq,
    input logic            irq_n_oe
);
    logic any_wr, any_rd;
    assign any_wr = (|fr_wr_en) | gl_wr_en;
    assign any_rd = (|fr_rd_en) | gl_rd_en;

    p_rd_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fr_rd_en, gl_rd_en}));

    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_rd |=> !any_rd);

    p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> !any_wr);

    p_wr_fanout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fr_wr_en) <= 1 || fr_wr_en == '1) && !(gl_wr_en && |fr_wr_en));

    p_wr_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |-> !data_oe);

    p_no_rdwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(any_wr && any_rd));

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_n_oe == $past(|fr_irq)));
endmodule

bind hostbus_bridge hostbus_bridge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fr_wr_en (fr_wr_en),
    .fr_rd_en (fr_rd_en),
    .gl_wr_en (gl_wr_en),
    .gl_rd_en (gl_rd_en),
    .data_oe  (data_oe),
    .fr_irq   (fr_irq),
    .irq_n_oe (irq_n_oe)
);

// File: tb/hostbus_bridge_bench.sv
`timescale 1ns/1ps
module hostbus_bridge_bench;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sep = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_ds_n = 1'b1;
    logic          wr_rw = 1'b1;
    logic [11:0]   addr = '0;
    logic [15:0]   data_in = '0;
    logic [15:0]   data_out;
    logic          data_oe;
    logic [7:0]    reg_addr;
    logic [15:0]   reg_wdata;
    logic [7:0]    fr_wr_en, fr_rd_en;
    logic [127:0]  fr_rdata;
    logic          gl_wr_en, gl_rd_en;
    logic [15:0]   gl_rdata;
    logic [7:0]    fr_irq = '0;
    logic          irq_n_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hostbus_bridge u_hostbus_bridge (
        .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .cs_n(cs_n),
        .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fr_wr_en(fr_wr_en), .fr_rd_en(fr_rd_en),
        .fr_rdata(fr_rdata), .gl_wr_en(gl_wr_en), .gl_rd_en(gl_rd_en),
        .gl_rdata(gl_rdata), .fr_irq(fr_irq), .irq_n_oe(irq_n_oe)
    );

    // Framer and global bank models: read data depends on channel and offset
    always_comb begin
        for (int c = 0; c < 8; c++)
            fr_rdata[c*16 +: 16] = (16'(c) << 12) | {8'h00, reg_addr};
        gl_rdata = {8'hC0, reg_addr};
    end

    typedef struct packed {
        logic        mode;
        logic        wr;
        logic [11:0] a;
        logic [15:0] d;
        logic [7:0]  exp_fr;
        logic        exp_gl;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 12'h345, 16'hBEEF, 8'h08, 1'b0, 16'h0000},
        '{1'b0, 1'b0, 12'h512, 16'h0000, 8'h20, 1'b0, 16'h5012},
        '{1'b1, 1'b1, 12'h67A, 16'h1234, 8'h40, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 12'h0FF, 16'h0000, 8'h01, 1'b0, 16'h00FF},
        '{1'b0, 1'b1, 12'h821, 16'h5A5A, 8'hFF, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 12'h821, 16'h0000, 8'h00, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 12'h910, 16'hCAFE, 8'h00, 1'b1, 16'h0000},
        '{1'b0, 1'b0, 12'h933, 16'h0000, 8'h00, 1'b1, 16'hC033},
        '{1'b0, 1'b0, 12'hD33, 16'h0000, 8'h00, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 12'hA01, 16'h7777, 8'h00, 1'b0, 16'h0000},
        '{1'b0, 1'b0, 12'hF00, 16'h0000, 8'h00, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 12'h7C4, 16'h0F0F, 8'h80, 1'b0, 16'h0000}
    };

    function automatic string vec_req(int i);
        case (i)
            0:       return "R2";
            1, 3:    return "R4";
            2:       return "R3";
            4:       return "R5";
            5:       return "R6";
            6, 7:    return "R7";
            11:      return "R11";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input int i);
        vec_t v = VECS[i];
        string rq = vec_req(i);
        mode_sep = v.mode;
        cs_n = 1'b0;
        addr = v.a;
        data_in = v.d;
        if (v.mode && v.wr) begin
            wr_rw = 1'b0;
            edges(3);
            chk(fr_wr_en == 8'h00 && !gl_wr_en, rq, "no write on falling strobe",
                {24'h0, fr_wr_en}, 32'h0);
            addr = v.a ^ 12'h300;
            wr_rw = 1'b1;
        end else begin
            wr_rw = ~v.wr;
            edges(1);
            rd_ds_n = 1'b0;
        end
        edges(3);
        if (v.wr) begin
            chk(fr_wr_en == v.exp_fr && gl_wr_en == v.exp_gl && fr_rd_en == 8'h00,
                rq, "write enables", {23'h0, gl_wr_en, fr_wr_en}, {23'h0, v.exp_gl, v.exp_fr});
            if (v.exp_fr != 8'h00 || v.exp_gl)
                chk(reg_addr == v.a[7:0] && reg_wdata == v.d, rq, "write addr/data",
                    {8'h0, reg_addr, reg_wdata}, {8'h0, v.a[7:0], v.d});
            edges(1);
            chk(fr_wr_en == 8'h00 && !gl_wr_en, rq, "write pulse single cycle",
                {23'h0, gl_wr_en, fr_wr_en}, 32'h0);
        end else begin
            chk(fr_rd_en == v.exp_fr && gl_rd_en == v.exp_gl && fr_wr_en == 8'h00,
                rq, "read enables", {23'h0, gl_rd_en, fr_rd_en}, {23'h0, v.exp_gl, v.exp_fr});
            chk(data_oe == 1'b1, rq, "bus driven during read", {31'h0, data_oe}, 32'h1);
            edges(1);
            chk(data_out == v.exp_rd && fr_rd_en == 8'h00, rq, "read data",
                {8'h0, fr_rd_en, data_out}, {16'h0, v.exp_rd});
        end
        rd_ds_n = 1'b1;
        wr_rw = 1'b1;
        edges(4);
        if (!v.wr)
            chk(data_oe == 1'b0, rq, "bus released after read", {31'h0, data_oe}, 32'h0);
        cs_n = 1'b1;
        edges(3);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int bad;
        edges(3);
        // R1: reset state
        chk(fr_wr_en == 0 && fr_rd_en == 0 && !gl_wr_en && !gl_rd_en && !data_oe
            && data_out == 0 && !irq_n_oe, "R1", "outputs in reset",
            {14'h0, data_oe, irq_n_oe, fr_wr_en, fr_rd_en}, 32'h0);
        rst_n = 1'b1;
        edges(2);
        chk(fr_wr_en == 0 && fr_rd_en == 0 && !data_oe && data_out == 0, "R1",
            "outputs after reset", {15'h0, data_oe, fr_wr_en, fr_rd_en}, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: strobes with chip select high, both modes
        for (int m = 0; m < 2; m++) begin
            mode_sep = m[0];
            cs_n = 1'b1;
            addr = 12'h2AA;
            data_in = 16'h1111;
            wr_rw = (m == 0) ? 1'b0 : 1'b1;
            edges(1);
            rd_ds_n = 1'b0;
            if (m == 1) wr_rw = 1'b0;
            bad = 0;
            for (int k = 0; k < 6; k++) begin
                edges(1);
                if (fr_wr_en != 0 || fr_rd_en != 0 || gl_wr_en || gl_rd_en || data_oe) bad++;
            end
            rd_ds_n = 1'b1;
            wr_rw = 1'b1;
            for (int k = 0; k < 6; k++) begin
                edges(1);
                if (fr_wr_en != 0 || fr_rd_en != 0 || gl_wr_en || gl_rd_en || data_oe) bad++;
            end
            chk(bad == 0, "R9", "activity while deselected", bad, 0);
        end

        // R10: interrupt merge, independent of chip select
        cs_n = 1'b1;
        fr_irq = 8'h20;
        edges(1);
        chk(irq_n_oe == 1'b1, "R10", "irq with cs high", {31'h0, irq_n_oe}, 1);
        cs_n = 1'b0;
        fr_irq = 8'h81;
        edges(1);
        chk(irq_n_oe == 1'b1, "R10", "irq with cs low", {31'h0, irq_n_oe}, 1);
        fr_irq = 8'h00;
        edges(1);
        chk(irq_n_oe == 1'b0, "R10", "irq released", {31'h0, irq_n_oe}, 0);
        cs_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule